// File: doc/BRIEF.md
# Instruction Cycle Phase Sequencer

This block is the hardwired control sequencer of a small accumulator-style processor. A two-bit phase register selects one of four fixed micro-operation sequences: fetch, indirect, execute and interrupt. A step counter supplies the timing slots inside each phase. In every clock cycle the sequencer raises one set of transfer enables for the program counter, memory address register, memory buffer register and instruction register, together with memory read and write strobes. The block also contains those registers and a behavioural word-addressed memory with single-cycle access.

The execute phase is not decoded here. On entry to execute, the sequencer pulses a start signal to a separate execute block and then waits for that block's done signal. The instruction word is 16 bits wide. Bits [15:13] hold the opcode, bit 12 is the indirect flag and bits [11:0] hold the address. The interrupt phase stores only the return address at a fixed save location and jumps to a fixed routine address. Saving any further state is left to the handler. A load port writes memory words directly, so program contents can be placed in memory before the sequencer runs.

Top module: `insn_cycle_seq`

## Requirements
- R1: In the first cycle after a synchronous reset, phase is 00 (fetch), step is 0, the program counter is 0 and the interrupt enable is 0.
- R2: The phase output reads 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. The step counter starts from 0 in the first cycle of every phase and advances by one each cycle.
- R3: Fetch step 0 copies the PC into the MAR. Fetch step 1 raises the memory read strobe, loads the MBR from memory at the MAR and increments the PC. Fetch step 2 loads the IR from the MBR.
- R4: After fetch step 2, the next phase is indirect when bit 12 of the fetched word is 1 and execute otherwise.
- R5: Indirect step 0 loads the MAR from IR[11:0]. Step 1 reads memory into the MBR. Step 2 replaces IR[11:0] with MBR[11:0] and leaves IR[15:12] unchanged. The next phase is execute.
- R6: The execute start output is high for exactly the first cycle of the execute phase. The phase stays at execute until the done input is high.
- R7: When done is high during execute, the next phase is interrupt if the interrupt enable is set and the request input is high. Otherwise the next phase is fetch, and the request is ignored.
- R8: Interrupt step 0 copies the PC into the MBR. Step 1 loads the MAR with the save address (default 0x010) and the PC with the routine address (default 0x020). Step 2 raises the write strobe and stores the MBR at the save address. The next phase is fetch, with the interrupt enable cleared.
- R9: A high level on the enable-set input sets the interrupt enable in the next cycle.
- R10: The read and write strobes are never high together. The read strobe is high only in step 1 of fetch or indirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request level |
| ex_done | input | 1 | Execute block has finished |
| int_en_set | input | 1 | Set the interrupt enable |
| ld_en | input | 1 | Memory load write enable |
| ld_addr | input | 12 | Memory load address |
| ld_data | input | 16 | Memory load data |
| ex_start | output | 1 | One-cycle start pulse to the execute block |
| phase | output | 2 | Current phase code |
| step | output | 2 | Current step within the phase |
| pc | output | 12 | Program counter |
| mar | output | 12 | Memory address register |
| mbr | output | 16 | Memory buffer register |
| ir | output | 16 | Instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| int_en | output | 1 | Interrupt enable state |

## Verification
The bench walks each phase cycle by cycle. In every step it checks the register that should have changed. A design that merged the memory read with the IR load would show a stale instruction one cycle early or late. The indirect path is checked with a word whose opcode bits must survive the address rewrite; a design that overwrote the whole IR would lose them. Interrupt handling is tested in two ways. A request with the enable clear must lead back to fetch. The saved return address is read back through an indirect fetch at the routine address, which exposes a missing or misdirected memory write and a PC saved before or after its increment.

// File: rtl/icps_pkg.sv
package icps_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 12;
    localparam int OP_W    = 3;
    localparam int IND_POS = ADDR_W;
    localparam int STEP_W  = 2;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic pc_inc;
        logic pc_from_isr;
        logic ir_from_mbr;
        logic ir_addr_from_mbr;
        logic mem_rd;
        logic mem_wr;
        logic ien_clr;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] addr_field(input logic [DATA_W-1:0] w);
        return w[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/phase_seq.sv
module phase_seq
    import icps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ind_bit,
    input  logic              ex_done,
    input  logic              irq,
    input  logic              ien,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output logic              ex_start,
    output ctrl_t             ctrl
);
    localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};
    localparam logic [STEP_W-1:0] LAST     = STEP_W'(2);

    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_FETCH: if (step == LAST) phase_nx = ind_bit ? PH_INDIR : PH_EXEC;
            PH_INDIR: if (step == LAST) phase_nx = PH_EXEC;
            PH_EXEC:  if (ex_done)      phase_nx = (ien && irq) ? PH_INTR : PH_FETCH;
            PH_INTR:  if (step == LAST) phase_nx = PH_FETCH;
            default:                    phase_nx = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            step  <= '0;
        end else begin
            phase <= phase_nx;
            if (phase_nx != phase)   step <= '0;
            else if (step != STEP_MAX) step <= step + STEP_W'(1);
        end
    end

    always_comb begin
        ctrl = '0;
        case (phase)
            PH_FETCH: case (step)
                2'd0:    ctrl.mar_from_pc = 1'b1;
                2'd1:    begin ctrl.mbr_from_mem = 1'b1; ctrl.mem_rd = 1'b1; ctrl.pc_inc = 1'b1; end
                2'd2:    ctrl.ir_from_mbr = 1'b1;
                default: ;
            endcase
            PH_INDIR: case (step)
                2'd0:    ctrl.mar_from_ir = 1'b1;
                2'd1:    begin ctrl.mbr_from_mem = 1'b1; ctrl.mem_rd = 1'b1; end
                2'd2:    ctrl.ir_addr_from_mbr = 1'b1;
                default: ;
            endcase
            PH_INTR: case (step)
                2'd0:    ctrl.mbr_from_pc = 1'b1;
                2'd1:    begin ctrl.mar_from_save = 1'b1; ctrl.pc_from_isr = 1'b1; end
                2'd2:    begin ctrl.mem_wr = 1'b1; ctrl.ien_clr = 1'b1; end
                default: ;
            endcase
            default: ;
        endcase
    end

    assign ex_start = (phase == PH_EXEC) && (step == '0);

    assert_no_rdwr_R10: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mem_rd && ctrl.mem_wr));
    assert_rd_slot_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_rd |-> ((phase == PH_FETCH || phase == PH_INDIR) && step == 2'd1));
    assert_step_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> (step == '0));
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        ex_start |=> !ex_start);
    assert_exec_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && !ex_done) |=> (phase == PH_EXEC));
    assert_fetch_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && step == LAST && !ind_bit) |=> (phase == PH_EXEC));
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && ex_done && !ien) |=> (phase == PH_FETCH));
endmodule

// File: rtl/word_store.sv
module word_store
    import icps_pkg::*;
#(
    parameter int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (ld_en)   cells[ld_addr] <= ld_data;
        else if (wr) cells[addr]    <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/xfer_regs.sv
module xfer_regs
    import icps_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h020
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              ien_set,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic              ien
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            ien <= 1'b0;
        end else begin
            if (ctrl.mar_from_pc)        mar <= pc;
            else if (ctrl.mar_from_ir)   mar <= addr_field(ir);
            else if (ctrl.mar_from_save) mar <= SAVE_ADDR;

            if (ctrl.mbr_from_mem)       mbr <= mem_q;
            else if (ctrl.mbr_from_pc)   mbr <= DATA_W'(pc);

            if (ctrl.pc_inc)             pc <= pc + ADDR_W'(1);
            else if (ctrl.pc_from_isr)   pc <= ISR_ADDR;

            if (ctrl.ir_from_mbr)        ir <= mbr;
            else if (ctrl.ir_addr_from_mbr) ir[ADDR_W-1:0] <= addr_field(mbr);

            if (ctrl.ien_clr)            ien <= 1'b0;
            else if (ien_set)            ien <= 1'b1;
        end
    end

    assert_pc_inc_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl.pc_inc |=> (pc == $past(pc) + ADDR_W'(1)));
    assert_ir_keep_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl.ir_addr_from_mbr |=> (ir[DATA_W-1:ADDR_W] == $past(ir[DATA_W-1:ADDR_W])));
    assert_intr_jump_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.pc_from_isr |=> (pc == ISR_ADDR && mar == SAVE_ADDR));
    assert_ien_set_R9: assert property (@(posedge clk) disable iff (rst)
        (ien_set && !ctrl.ien_clr) |=> ien);
endmodule

// File: rtl/insn_cycle_seq.sv
module insn_cycle_seq
    import icps_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h020
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq,
    input  logic              ex_done,
    input  logic              int_en_set,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              ex_start,
    output logic [1:0]        phase,
    output logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              int_en
);
    ctrl_t             ctrl;
    phase_e            ph;
    logic [DATA_W-1:0] mem_q;

    phase_seq u_seq (
        .clk(clk), .rst(rst), .ind_bit(mbr[IND_POS]), .ex_done(ex_done),
        .irq(irq), .ien(int_en), .phase(ph), .step(step),
        .ex_start(ex_start), .ctrl(ctrl)
    );

    xfer_regs #(.SAVE_ADDR(SAVE_ADDR), .ISR_ADDR(ISR_ADDR)) u_regs (
        .clk(clk), .rst(rst), .ctrl(ctrl), .ien_set(int_en_set), .mem_q(mem_q),
        .pc(pc), .mar(mar), .mbr(mbr), .ir(ir), .ien(int_en)
    );

    word_store u_mem (
        .clk(clk), .wr(ctrl.mem_wr), .addr(mar), .wdata(mbr),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .rdata(mem_q)
    );

    assign phase  = ph;
    assign mem_rd = ctrl.mem_rd;
    assign mem_wr = ctrl.mem_wr;
endmodule

// File: tb/sim_insn_cycle_seq.sv
module sim_insn_cycle_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0, ex_done = 1'b0, int_en_set = 1'b0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        ex_start, mem_rd, mem_wr, int_en;
    logic [1:0]  phase, step;
    logic [11:0] pc, mar;
    logic [15:0] mbr, ir;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    insn_cycle_seq u0 (
        .clk(clk), .rst(rst), .irq(irq), .ex_done(ex_done), .int_en_set(int_en_set),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .ex_start(ex_start),
        .phase(phase), .step(step), .pc(pc), .mar(mar), .mbr(mbr), .ir(ir),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .int_en(int_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int a, input int d);
        ld_en = 1'b1; ld_addr = 12'(a); ld_data = 16'(d);
        tick();
        ld_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic t_reset();
        load(12'h000, 16'hA123);
        load(12'h001, 16'h3040);
        load(12'h040, 16'h0ABC);
        load(12'h002, 16'h4005);
        load(12'h020, 16'h1010);
        tick();
        rst = 1'b0;
        chk("R1", "phase", phase, 0);
        chk("R1", "step", step, 0);
        chk("R1", "pc", pc, 0);
        chk("R1", "int_en", int_en, 0);
        chk("R10", "rd at fetch t1", mem_rd, 0);
    endtask

    task automatic t_fetch_direct();
        tick();
        chk("R3", "mar after t1", mar, 0);
        chk("R3", "rd in t2", mem_rd, 1);
        chk("R2", "step t2", step, 1);
        tick();
        chk("R3", "mbr after t2", mbr, 16'hA123);
        chk("R3", "pc incremented", pc, 1);
        tick();
        chk("R4", "direct goes to execute", phase, 2);
        chk("R2", "step restart", step, 0);
        chk("R3", "ir loaded", ir, 16'hA123);
        chk("R6", "start pulse", ex_start, 1);
        tick();
        chk("R6", "start drops", ex_start, 0);
        chk("R6", "waits in execute", phase, 2);
        ex_done = 1'b1;
        tick();
        ex_done = 1'b0;
        chk("R7", "back to fetch", phase, 0);
        chk("R7", "pc kept", pc, 1);
    endtask

    task automatic t_indirect();
        tick(); tick(); tick();
        chk("R4", "indirect phase", phase, 1);
        chk("R2", "indirect step0", step, 0);
        chk("R3", "ir before rewrite", ir, 16'h3040);
        tick();
        chk("R5", "mar from ir addr", mar, 12'h040);
        chk("R10", "rd in indirect t2", mem_rd, 1);
        tick();
        chk("R5", "mbr pointer word", mbr, 16'h0ABC);
        tick();
        chk("R5", "then execute", phase, 2);
        chk("R5", "ir rewritten", ir, 16'h3ABC);
        chk("R5", "pc", pc, 2);
    endtask

    task automatic t_irq_masked();
        irq = 1'b1; ex_done = 1'b1;
        tick();
        ex_done = 1'b0;
        chk("R7", "masked request ignored", phase, 0);
        chk("R7", "pc unchanged", pc, 2);
    endtask

    task automatic t_interrupt();
        tick(); tick(); tick();
        chk("R4", "exec after fetch of 0x4005", phase, 2);
        int_en_set = 1'b1;
        tick();
        int_en_set = 1'b0;
        chk("R9", "enable set", int_en, 1);
        ex_done = 1'b1;
        tick();
        ex_done = 1'b0; irq = 1'b0;
        chk("R7", "interrupt taken", phase, 3);
        chk("R10", "no write in t1", mem_wr, 0);
        tick();
        chk("R8", "mbr holds pc", mbr, 3);
        tick();
        chk("R8", "mar save addr", mar, 12'h010);
        chk("R8", "pc routine addr", pc, 12'h020);
        chk("R8", "write strobe", mem_wr, 1);
        chk("R10", "no read with write", mem_rd, 0);
        tick();
        chk("R8", "fetch after interrupt", phase, 0);
        chk("R8", "enable cleared", int_en, 0);
        tick(); tick(); tick();
        chk("R4", "routine word indirect", phase, 1);
        tick(); tick(); tick();
        chk("R8", "saved return addr in memory", mbr, 3);
        chk("R5", "ir from saved addr", ir, 16'h1003);
        chk("R8", "pc after routine fetch", pc, 12'h021);
    endtask

    initial begin
        t_reset();
        t_fetch_direct();
        t_indirect();
        t_irq_masked();
        t_interrupt();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule